// File: doc/BRIEF.md
# Backlog-Driven Link Supply Selector

This block decides which of two supply rails feeds the drivers of a long on-chip link. It watches how many words are waiting in the transmit FIFO. When the backlog climbs past a programmable upper level it selects the normal (higher) supply, so the link can carry more traffic. When the backlog drains below a separate, lower level it falls back to the low supply to save energy. The band between the two levels is hysteresis: inside it the choice does not change.

The select line travels down the link next to the data wires, so the time a change takes is set mostly by how fast that control signal propagates. The block does not wait for an acknowledge from the far end. After it raises the select, it counts a programmed lead time. When the count ends it declares the link switched, because the control signal moves at least as fast as the data that follows it. A separate status flag reports the bandwidth mode the sender may use. That flag rises only when the lead count ends, and it drops in the same cycle that the select drops. A programmable hold time stops the select from changing again too soon after any change.

The controller is a three-state machine. In `LOW_SUPPLY` the low rail is selected and the status flag is 0. In `LEAD_WAIT` the normal rail is selected but the lead count is still running, so the status flag stays 0. In `HIGH_SUPPLY` the normal rail is selected and the status flag is 1. There are three transitions. *raise* goes from `LOW_SUPPLY` to `LEAD_WAIT`. *settle* goes from `LEAD_WAIT` to `HIGH_SUPPLY`. *drop* goes from `HIGH_SUPPLY` to `LOW_SUPPLY`.

Top module: `link_supply_sel`

## Requirements
- R1: While reset is low, `supply_hi` and `rate_fast` are 0. Reset acts asynchronously. The hold time counts as already elapsed after reset, so a raise can happen at the first clock edge after reset is released.
- R2: In `LOW_SUPPLY` with the hold time elapsed, if `fifo_fill > raise_level` at a clock edge, then `supply_hi` is 1 after that edge (*raise*).
- R3: The raise test is strict. A backlog equal to `raise_level` never raises the select.
- R4: In `HIGH_SUPPLY` with the hold time elapsed, if `fifo_fill < lower_level` at a clock edge, then `supply_hi` and `rate_fast` are both 0 after that edge (*drop*).
- R5: Hysteresis. With the low rail selected, a backlog at or below `raise_level` keeps it selected. With the normal rail selected, a backlog at or above `lower_level` keeps it selected (equality with `lower_level` does not drop).
- R6: `rate_fast` rises exactly `lead_cycles + 1` clock cycles after `supply_hi` rises (*settle*). It is 0 before that point.
- R7: A raise is never aborted. While `LEAD_WAIT` lasts, `supply_hi` stays 1 whatever the backlog is.
- R8: After any change of `supply_hi`, the next change cannot come earlier than `hold_cycles + 1` cycles later. If the condition for the next change is still present and the lead time has ended, the change comes at exactly that point.
- R9: `rate_fast` is never 1 unless `supply_hi` has already been 1 for at least one earlier cycle.
- R10: `lead_cycles` is captured on *raise*. Changing it during `LEAD_WAIT` does not change when *settle* happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_fill | input | FILL_W | Current transmit FIFO occupancy in words |
| raise_level | input | FILL_W | Backlog above which the normal supply is chosen |
| lower_level | input | FILL_W | Backlog below which the low supply is chosen |
| lead_cycles | input | TIMER_W | Propagation lead, in cycles, counted before the link is declared switched |
| hold_cycles | input | TIMER_W | Minimum spacing between select changes; captured at each change |
| supply_hi | output | 1 | Supply select sent along the link: 1 = normal rail, 0 = low rail |
| rate_fast | output | 1 | Bandwidth mode status: 1 = higher-rate mode may be used |

## Verification
If the state register is wrong, the fault shows on `supply_hi` or `rate_fast` in the cycle right after the edge where the wrong transition happens. This is because both outputs are decoded directly from the state. If the lead counter is wrong, the *settle* edge of `rate_fast` moves earlier or later than `lead_cycles + 1` cycles after the raise. If the hold counter is wrong, the select changes before or after the `hold_cycles + 1` spacing. Either fault can be seen within a few cycles of a single raise or drop, so the bench holds the backlog steady and counts the exact edge on which each change appears.

// File: rtl/supsel_pkg.sv
package supsel_pkg;

    // Controller states; encoding is not decoded outside the FSM.
    typedef enum logic [1:0] {
        LOW_SUPPLY  = 2'd0,
        LEAD_WAIT   = 2'd1,
        HIGH_SUPPLY = 2'd2
    } sup_state_e;

endpackage

// File: rtl/supsel_level_cmp.sv
module supsel_level_cmp #(
    parameter int FILL_W = 6
) (
    input  logic [FILL_W-1:0] fill,
    input  logic [FILL_W-1:0] upper,
    input  logic [FILL_W-1:0] lower,
    output logic              above_upper,
    output logic              below_lower
);

    // Both comparisons are strict, so equality keeps the current rail.
    always_comb begin
        above_upper = (fill > upper);
        below_lower = (fill < lower);
    end

endmodule

// File: rtl/supsel_countdown.sv
module supsel_countdown #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] remain;

    // Loads on request, otherwise counts down to zero and stays there.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign expired = (remain == '0);

endmodule

// File: rtl/supsel_fsm.sv
module supsel_fsm
    import supsel_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic above_upper,
    input  logic below_lower,
    input  logic hold_done,
    input  logic lead_done,
    output logic raise_evt,
    output logic drop_evt,
    output logic sel_high,
    output logic mode_fast
);

    sup_state_e state_q;
    sup_state_e state_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LOW_SUPPLY;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and transition events.
    always_comb begin
        state_d   = state_q;
        raise_evt = 1'b0;
        drop_evt  = 1'b0;
        unique case (state_q)
            LOW_SUPPLY: begin
                if (above_upper && hold_done) begin
                    state_d   = LEAD_WAIT;   // raise
                    raise_evt = 1'b1;
                end
            end
            LEAD_WAIT: begin
                if (lead_done) begin
                    state_d = HIGH_SUPPLY;   // settle
                end
            end
            HIGH_SUPPLY: begin
                if (below_lower && hold_done) begin
                    state_d  = LOW_SUPPLY;   // drop
                    drop_evt = 1'b1;
                end
            end
            default: begin
                state_d = LOW_SUPPLY;
            end
        endcase
    end

    // Output decode from the state register.
    always_comb begin
        sel_high  = 1'b0;
        mode_fast = 1'b0;
        unique case (state_q)
            LOW_SUPPLY:  begin sel_high = 1'b0; mode_fast = 1'b0; end
            LEAD_WAIT:   begin sel_high = 1'b1; mode_fast = 1'b0; end
            HIGH_SUPPLY: begin sel_high = 1'b1; mode_fast = 1'b1; end
            default:     begin sel_high = 1'b0; mode_fast = 1'b0; end
        endcase
    end

endmodule

// File: rtl/link_supply_sel.sv
module link_supply_sel #(
    parameter int FILL_W  = 6,
    parameter int TIMER_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FILL_W-1:0]  fifo_fill,
    input  logic [FILL_W-1:0]  raise_level,
    input  logic [FILL_W-1:0]  lower_level,
    input  logic [TIMER_W-1:0] lead_cycles,
    input  logic [TIMER_W-1:0] hold_cycles,
    output logic               supply_hi,
    output logic               rate_fast
);

    logic above_upper;
    logic below_lower;
    logic hold_done;
    logic lead_done;
    logic raise_evt;
    logic drop_evt;
    logic any_change;

    supsel_level_cmp #(.FILL_W(FILL_W)) u_cmp (
        .fill        (fifo_fill),
        .upper       (raise_level),
        .lower       (lower_level),
        .above_upper (above_upper),
        .below_lower (below_lower)
    );

    assign any_change = raise_evt | drop_evt;

    // Minimum spacing between select changes.
    supsel_countdown #(.W(TIMER_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (any_change),
        .load_val (hold_cycles),
        .expired  (hold_done)
    );

    // Propagation lead of the control signal ahead of the data.
    supsel_countdown #(.W(TIMER_W)) u_lead (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (raise_evt),
        .load_val (lead_cycles),
        .expired  (lead_done)
    );

    supsel_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .above_upper (above_upper),
        .below_lower (below_lower),
        .hold_done   (hold_done),
        .lead_done   (lead_done),
        .raise_evt   (raise_evt),
        .drop_evt    (drop_evt),
        .sel_high    (supply_hi),
        .mode_fast   (rate_fast)
    );

endmodule

// File: rtl/link_supply_sel_chk.sv
module link_supply_sel_chk #(
    parameter int FILL_W  = 6,
    parameter int TIMER_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [FILL_W-1:0]  fifo_fill,
    input logic [FILL_W-1:0]  raise_level,
    input logic [FILL_W-1:0]  lower_level,
    input logic [TIMER_W-1:0] hold_cycles,
    input logic               hold_done,
    input logic               supply_hi,
    input logic               rate_fast
);

    localparam int SW = TIMER_W + 1;

    logic               sel_q;
    logic [SW-1:0]      since_chg;
    logic [TIMER_W-1:0] hold_lat;

    // Tracks cycles since the last select change, for the spacing rule.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q     <= 1'b0;
            since_chg <= '1;
            hold_lat  <= '0;
        end else begin
            sel_q <= supply_hi;
            if (supply_hi != sel_q) begin
                since_chg <= SW'(1);
                hold_lat  <= hold_cycles;
            end else if (since_chg != '1) begin
                since_chg <= since_chg + 1'b1;
            end
        end
    end

    // R2
    a_r2_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (!supply_hi && hold_done && (fifo_fill > raise_level)) |=> supply_hi);

    // R4
    a_r4_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_fast && hold_done && (fifo_fill < lower_level)) |=> (!supply_hi && !rate_fast));

    // R5 and R3
    a_r5_low_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!supply_hi && (fifo_fill <= raise_level)) |=> !supply_hi);

    // R5
    a_r5_high_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_fast && (fifo_fill >= lower_level)) |=> supply_hi);

    // R7
    a_r7_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_hi && !rate_fast) |=> supply_hi);

    // R8
    a_r8_hold_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_hi != sel_q) |-> (since_chg > {1'b0, hold_lat}));

    // R9
    a_r9_fast_after_sel: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rate_fast) |-> $past(supply_hi));

endmodule

bind link_supply_sel link_supply_sel_chk #(.FILL_W(FILL_W), .TIMER_W(TIMER_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fifo_fill   (fifo_fill),
    .raise_level (raise_level),
    .lower_level (lower_level),
    .hold_cycles (hold_cycles),
    .hold_done   (hold_done),
    .supply_hi   (supply_hi),
    .rate_fast   (rate_fast)
);

// File: tb/link_supply_sel_test.sv
`timescale 1ns/1ps
module link_supply_sel_test;

    localparam int FILL_W  = 6;
    localparam int TIMER_W = 8;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [FILL_W-1:0]  fifo_fill = '0;
    logic [FILL_W-1:0]  raise_level = 6'd40;
    logic [FILL_W-1:0]  lower_level = 6'd20;
    logic [TIMER_W-1:0] lead_cycles = 8'd2;
    logic [TIMER_W-1:0] hold_cycles = 8'd3;
    logic               supply_hi;
    logic               rate_fast;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #10 clk = ~clk;   // 50 MHz

    link_supply_sel #(.FILL_W(FILL_W), .TIMER_W(TIMER_W)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .fifo_fill   (fifo_fill),
        .raise_level (raise_level),
        .lower_level (lower_level),
        .lead_cycles (lead_cycles),
        .hold_cycles (hold_cycles),
        .supply_hi   (supply_hi),
        .rate_fast   (rate_fast)
    );

    // One clock edge, then settle away from the edge.
    task automatic step();
        @(posedge clk);
        #5;
    endtask

    task automatic expect_out(input logic exp_sel, input logic exp_fast, input string req);
        checks++;
        if (supply_hi !== exp_sel || rate_fast !== exp_fast) begin
            failures++;
            $display("FAIL %s: sel=%b fast=%b expected sel=%b fast=%b at %0t",
                     req, supply_hi, rate_fast, exp_sel, exp_fast, $time);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step();
        step();
        expect_out(1'b0, 1'b0, "R1 reset state");
        rst_n = 1'b1;
        fifo_fill = 6'd30;
        repeat (4) step();
        expect_out(1'b0, 1'b0, "R5 mid-band stays low");
    endtask

    task automatic t_strict();
        fifo_fill = 6'd40;
        for (int i = 0; i < 6; i++) begin
            step();
            expect_out(1'b0, 1'b0, "R3 equal to raise level");
        end
    endtask

    task automatic t_rise();
        fifo_fill = 6'd41;
        step();
        expect_out(1'b1, 1'b0, "R2 raise");
        lead_cycles = 8'd9;     // R10: change ignored during lead
        step();
        expect_out(1'b1, 1'b0, "R6 lead 1");
        step();
        expect_out(1'b1, 1'b0, "R6 lead 2");
        step();
        expect_out(1'b1, 1'b1, "R6 R10 settle after lead+1");
        lead_cycles = 8'd2;
        fifo_fill = 6'd30;
        repeat (3) step();
        expect_out(1'b1, 1'b1, "R5 mid-band stays high");
        fifo_fill = 6'd20;
        repeat (3) step();
        expect_out(1'b1, 1'b1, "R5 equal to lower level");
        fifo_fill = 6'd19;
        step();
        expect_out(1'b0, 1'b0, "R4 drop");
    endtask

    task automatic t_no_abort();
        fifo_fill = 6'd30;
        repeat (5) step();
        fifo_fill = 6'd41;
        step();
        expect_out(1'b1, 1'b0, "R2 raise again");
        fifo_fill = 6'd0;
        step();
        expect_out(1'b1, 1'b0, "R7 lead kept 1");
        step();
        expect_out(1'b1, 1'b0, "R7 lead kept 2");
        step();
        expect_out(1'b1, 1'b1, "R7 R6 settle despite empty queue");
        step();
        expect_out(1'b0, 1'b0, "R4 R8 drop at hold end");
    endtask

    task automatic t_hold();
        hold_cycles = 8'd6;
        lead_cycles = 8'd0;
        fifo_fill = 6'd30;
        repeat (8) step();
        fifo_fill = 6'd41;
        step();
        expect_out(1'b1, 1'b0, "R2 raise with zero lead");
        fifo_fill = 6'd0;
        step();
        expect_out(1'b1, 1'b1, "R6 zero lead settles next cycle");
        for (int i = 0; i < 5; i++) begin
            step();
            expect_out(1'b1, 1'b1, "R8 hold blocks drop");
        end
        step();
        expect_out(1'b0, 1'b0, "R8 drop at hold+1");
        fifo_fill = 6'd63;
        for (int i = 0; i < 6; i++) begin
            step();
            expect_out(1'b0, 1'b0, "R8 hold blocks raise");
        end
        step();
        expect_out(1'b1, 1'b0, "R8 raise at hold+1");
        step();
        expect_out(1'b1, 1'b1, "R6 settle");
    endtask

    task automatic t_reset_mid();
        rst_n = 1'b0;
        #1;
        expect_out(1'b0, 1'b0, "R1 asynchronous reset");
        step();
        rst_n = 1'b1;
        fifo_fill = 6'd63;
        step();
        expect_out(1'b1, 1'b0, "R1 hold elapsed after reset");
    endtask

    initial begin
        #4_000_000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_strict();
        t_rise();
        t_no_abort();
        t_hold();
        t_reset_mid();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule